// File: doc/BRIEF.md
# Per-Channel Control Bit Serializer

This block sends out, on one serial pin, a single control bit for every stream/channel position of a time-division frame. There is one bit per clock, so a frame of `STREAMS x CHANNELS` positions takes as many clocks as it has positions. The bits sit in a one-bit-wide memory. A write port loads that memory from full connection words, and only the control bit position of each word is kept. The serializer reads the memory back in a fixed interleaved order: within each channel time, stream 0 goes first and the highest stream goes last.

The sequence runs one channel time ahead of the transmit data that it controls. This gives external circuits a full channel time to act on each bit before the matching time slot arrives. While the transmitter is sending channel `c`, the pin carries the bits of channel `c+1`. The bits of channel 0 therefore go out during the last channel time of the previous frame.

A single-cycle frame pulse aligns the block. The clock after the pulse is slot 0: channel 0, bit position 7. After reset the pin is held low until the first frame pulse is seen.

Top module: `cbs_ctrl_serializer`

## Requirements
- R1: From reset until the first `frame_sync` pulse is sampled, `ctl_ser` is 0, whatever the memory holds and whatever writes occur.
- R2: The clock after a sampled `frame_sync` is slot 0. The slot number then rises by one per clock and wraps from `STREAMS*CHANNELS-1` (255) to 0 without a new pulse.
- R3: In slot `s = 8*c + k` (TX channel `c`, bit position `7-k`), `ctl_ser` carries the stored bit of channel `(c+1) mod 32`, stream `k`. This puts channel 0's bits in TX channel 31.
- R4: Within one channel time, stream `k` goes out in the `k`-th clock, so stream 0 comes first, at bit position 7.
- R5: The stored control bit is bit 1 of `wr_word`. All other bits of `wr_word` have no effect on `ctl_ser`.
- R6: A `frame_sync` pulse in the middle of a frame restarts the sequence at slot 0 in the next clock.
- R7: A write with `wr_en` high stores the bit at entry `wr_addr = channel*8 + stream`. The new value is used by every read issued after the write clock.
- R8: Synchronous active-high `rst` clears the alignment, so `ctl_ser` goes back to 0 until the next frame pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | Single-cycle pulse; the following cycle is slot 0 |
| wr_en | input | 1 | Write strobe for the control-bit memory |
| wr_addr | input | 8 | Entry index, channel*STREAMS + stream |
| wr_word | input | 8 | Connection word; only bit CTRL_BIT (1) is stored |
| ctl_ser | output | 1 | Registered serial control bit |

## Verification
The bench loads several memory patterns and checks every slot of whole frames. Two of those patterns have a single one bit. One is at channel 0, stream 0, and must appear in the first slot of TX channel 31. If the design left out the one-channel advance, or indexed channel-major where it should interleave by stream, that bit would show up in the wrong slot. Words are written with every other bit set to the inverse of bit 1, so a design that stores the wrong bit position gives an inverted stream. The bench also sends a pulse in the middle of a frame, applies a reset while the serializer is running, and checks the slot just after each pulse. An off-by-one read address, or a read that is not issued ahead of time, would lose the first bit after realignment.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  // Modular addition for slot arithmetic: a + b wrapped into [0, m).
  function automatic int unsigned wrap_add(int unsigned a, int unsigned b, int unsigned m);
    int unsigned s;
    s = a + b;
    return (s >= m) ? (s - m) : s;
  endfunction
endpackage

// File: rtl/cbs_slot_counter.sv
module cbs_slot_counter #(
  parameter int SLOTS  = 256,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_sync,
  output logic [SLOT_W-1:0] slot_q,
  output logic [SLOT_W-1:0] slot_nx,
  output logic              synced_q,
  output logic              synced_nx
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  // Next slot is exposed so the memory read can be issued one clock early.
  always_comb begin
    if (frame_sync)          slot_nx = '0;
    else if (slot_q == LAST) slot_nx = '0;
    else                     slot_nx = slot_q + 1'b1;
  end

  assign synced_nx = synced_q | frame_sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q   <= '0;
      synced_q <= 1'b0;
    end else begin
      slot_q   <= slot_nx;
      synced_q <= synced_nx;
    end
  end
endmodule

// File: rtl/cbs_ctrl_ram.sv
module cbs_ctrl_ram #(
  parameter int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic              wbit,
  input  logic              rd_gate,
  input  logic [ADDR_W-1:0] raddr,
  output logic              rbit_q
);
  logic mem [DEPTH];

  // Write port: plain registered write, suitable for block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wbit;
  end

  // Read port: registered output with synchronous reset and a gate that
  // forces zero while the sequencer is not yet aligned.
  always_ff @(posedge clk) begin
    if (rst)          rbit_q <= 1'b0;
    else if (rd_gate) rbit_q <= mem[raddr];
    else              rbit_q <= 1'b0;
  end
endmodule

// File: rtl/cbs_ctrl_serializer.sv
module cbs_ctrl_serializer #(
  parameter int STREAMS  = 8,
  parameter int CHANNELS = 32,
  parameter int WORD_W   = 8,
  parameter int CTRL_BIT = 1,
  parameter int LEAD_CH  = 1,
  localparam int SLOTS   = STREAMS * CHANNELS,
  localparam int ADDR_W  = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_sync,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_word,
  output logic              ctl_ser
);
  localparam int unsigned LEAD = STREAMS * LEAD_CH;

  logic [ADDR_W-1:0] slot_q;
  logic [ADDR_W-1:0] slot_nx;
  logic              synced_q;
  logic              synced_nx;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_bit_q;

  cbs_slot_counter #(.SLOTS(SLOTS)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .frame_sync(frame_sync),
    .slot_q    (slot_q),
    .slot_nx   (slot_nx),
    .synced_q  (synced_q),
    .synced_nx (synced_nx)
  );

  // Slot s = chan*STREAMS + k needs entry ((chan+LEAD_CH) mod CHANNELS)*STREAMS + k,
  // which is simply (s + LEAD) mod SLOTS; it is fetched for the next slot.
  assign rd_addr = ADDR_W'(cbs_pkg::wrap_add(32'(slot_nx), LEAD, SLOTS));

  cbs_ctrl_ram #(.DEPTH(SLOTS)) u_ram (
    .clk    (clk),
    .rst    (rst),
    .we     (wr_en),
    .waddr  (wr_addr),
    .wbit   (wr_word[CTRL_BIT]),
    .rd_gate(synced_nx),
    .raddr  (rd_addr),
    .rbit_q (rd_bit_q)
  );

  assign ctl_ser = rd_bit_q;
endmodule

// File: rtl/cbs_ctrl_serializer_chk.sv
module cbs_ctrl_serializer_chk #(
  parameter int STREAMS  = 8,
  parameter int CHANNELS = 32,
  parameter int WORD_W   = 8,
  parameter int CTRL_BIT = 1,
  parameter int LEAD_CH  = 1,
  localparam int SLOTS   = STREAMS * CHANNELS,
  localparam int ADDR_W  = $clog2(SLOTS)
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_sync,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [WORD_W-1:0] wr_word,
  input logic              ctl_ser,
  input logic [ADDR_W-1:0] slot_q,
  input logic [ADDR_W-1:0] rd_addr
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(SLOTS - 1);

  logic              shadow [SLOTS];
  logic              armed_q;
  logic              coll_q;
  logic [ADDR_W-1:0] raddr_q;

  always_ff @(posedge clk) begin
    if (wr_en) shadow[wr_addr] <= wr_word[CTRL_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      coll_q  <= 1'b0;
      raddr_q <= '0;
    end else begin
      armed_q <= armed_q | frame_sync;
      coll_q  <= wr_en && (wr_addr == rd_addr);
      raddr_q <= rd_addr;
    end
  end

  AST_LOW_UNTIL_SYNC: assert property (@(posedge clk) disable iff (rst)
    !armed_q |-> !ctl_ser); // R1

  AST_SYNC_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    frame_sync |=> (slot_q == '0)); // R6

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!frame_sync && slot_q != LAST) |=> (slot_q == $past(slot_q) + 1'b1)); // R2

  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!frame_sync && slot_q == LAST) |=> (slot_q == '0)); // R2

  AST_BIT_MATCH: assert property (@(posedge clk) disable iff (rst)
    (armed_q && !coll_q) |-> (ctl_ser == shadow[raddr_q])); // R3 (also R5, R7)
endmodule

bind cbs_ctrl_serializer cbs_ctrl_serializer_chk #(
  .STREAMS (STREAMS),
  .CHANNELS(CHANNELS),
  .WORD_W  (WORD_W),
  .CTRL_BIT(CTRL_BIT),
  .LEAD_CH (LEAD_CH)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .frame_sync(frame_sync),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_word   (wr_word),
  .ctl_ser   (ctl_ser),
  .slot_q    (slot_q),
  .rd_addr   (rd_addr)
);

// File: tb/cbs_ctrl_serializer_tb_top.sv
module cbs_ctrl_serializer_tb_top;
  localparam int ST = 8;
  localparam int CH = 32;
  localparam int SL = ST * CH;
  localparam int WW = 8;
  localparam int CB = 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frame_sync = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_addr = '0;
  logic [WW-1:0] wr_word = '0;
  logic          ctl_ser;

  int   checks = 0;
  int   errors = 0;
  int   slot = 0;
  logic model [SL];

  always #2 clk = ~clk;

  cbs_ctrl_serializer dut_i (
    .clk(clk), .rst(rst), .frame_sync(frame_sync),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_word(wr_word), .ctl_ser(ctl_ser)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s slot=%0d actual=%0b expected=%0b", req, slot, act, exp);
    end
  endtask

  function automatic logic pat(int idx, int kind);
    case (kind)
      0:       return logic'(((idx * 37 + (idx >> 3) * 5 + 11) >> 2) & 1);
      1:       return logic'(idx == 0);
      2:       return logic'(idx == 5 * ST + 3);
      3:       return logic'((idx & 1) ^ ((idx >> 3) & 1));
      default: return 1'b1;
    endcase
  endfunction

  // Load every entry; other word bits are the inverse of the control bit (R5).
  task automatic fill(int kind, bit expect_low);
    for (int i = 0; i < SL; i++) begin
      @(negedge clk);
      if (expect_low) check("R1", ctl_ser, 1'b0);
      wr_en   = 1'b1;
      wr_addr = 8'(i);
      wr_word = {WW{~pat(i, kind)}};
      wr_word[CB] = pat(i, kind);
      model[i] = pat(i, kind);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk) frame_sync = 1'b1;
    @(negedge clk) frame_sync = 1'b0;
    slot = 0;
  endtask

  // Expected bit in slot s: entry (s + ST) mod SL (R3, R4).
  task automatic run(int n, string req);
    for (int i = 0; i < n; i++) begin
      check(req, ctl_ser, model[(slot + ST) % SL]);
      slot = (slot + 1) % SL;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8", ctl_ser, 1'b0);
    rst = 1'b0;
    fill(0, 1'b1);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check("R1", ctl_ser, 1'b0);
    end
    pulse();
    run(2 * SL, "R2");            // two frames, free wrap
    fill(1, 1'b0);
    pulse();
    run(SL, "R3");                // ch0 st0 must appear at slot 248
    fill(2, 1'b0);
    pulse();
    run(SL, "R4");
    fill(3, 1'b0);
    pulse();
    run(SL, "R5");
    run(100, "R6");
    pulse();
    run(40, "R6");
    fill(4, 1'b0);
    pulse();
    run(SL, "R7");
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    for (int i = 0; i < 300; i++) begin
      check("R8", ctl_ser, 1'b0);
      @(negedge clk);
    end
    fill(0, 1'b1);
    pulse();
    run(64, "R8");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog timeout");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule